// File: doc/BRIEF.md
# Indirect cache access address unit

This block is a 32-bit control register paired with an address generator. Software reaches three small internal caches (a command cache, an expected-data cache and a read-data cache) through one configuration register and a data window, never addressing the cache storage directly. The register holds two independent pointers, one used for cache writes and one for cache reads. Each pointer is a word index plus a slice index. It also holds an access-kind bit, an auto-step enable and a two-bit target selector.

On each strobe of the data window the block drives the selected cache with the active pointer, a one-hot chip select and a write enable. A read returns the addressed slice on the data window one clock later. With auto-step enabled, the pointer that was used moves to the next slice after the access and moves to the next word only after the last slice of the current word. The slice and word counts come from per-cache parameters.

Top module: `cache_addr_unit`

## Requirements
- R1: After reset the register reads 0x00000000 and the data window reads zero; bits 31:20 always read as zero, whatever software writes to them.
- R2: Register layout: read-pointer slice in bits 19:16, read-pointer word in 15:12, access kind in bit 11, auto-step enable in bit 10, target select in 9:8, write-pointer slice in 7:4, write-pointer word in 3:0; every one of these fields reads back what software last wrote.
- R3: With access kind 0, a data strobe writes the data-window input into the selected cache at the write pointer with the cache write enable high. With access kind 1, it reads the selected cache at the read pointer with the write enable low.
- R4: Chip select is one-hot and is driven only during a data strobe: bit 0 for target code 00 (command cache), bit 1 for 01 (expected-data cache), bit 2 for 10 (read-data cache).
- R5: With target code 11 a data strobe raises no chip select and no write enable, a read returns zero on the data window, and neither pointer moves.
- R6: With the auto-step enable clear, data strobes leave both pointers unchanged.
- R7: With the auto-step enable set, the active pointer's slice index rises by one per access. Past the selected cache's last slice it returns to 0 and the word index rises by one. Past that cache's last word the word index returns to 0.
- R8: A write access steps only the write pointer and a read access steps only the read pointer.
- R9: A register write in the same cycle as a data strobe takes priority: the register afterwards holds the written value and the step is dropped. The access itself still uses the old pointer.
- R10: Read data appears on the data window at the clock edge that follows the read strobe. The pointer step becomes visible at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value |
| dat_acc | input | 1 | Data-window access strobe |
| dat_wdata | input | DW | Data-window write value |
| dat_rdata | output | DW | Data-window read value, registered |
| cache_cs | output | 3 | One-hot cache select |
| cache_we | output | 1 | Cache write enable |
| cache_word | output | 4 | Word index toward the caches |
| cache_slice | output | 4 | Slice index toward the caches |
| cache_wdata | output | DW | Write data toward the caches |
| cmd_rdata | input | DW | Command cache read data |
| exp_rdata | input | DW | Expected-data cache read data |
| rdd_rdata | input | DW | Read-data cache read data |

## Verification
The assertions assume that the cache read-data inputs depend only on the address lines in the same cycle, and that the register is never written with a pointer beyond the selected cache's size. The bench models each cache as a pure function of target, word and slice. It loads only in-range pointers, so its own linear-index model of the stepping order stays valid. Register writes overlap a data strobe only in the single cycle that deliberately tests the priority rule.

// File: rtl/cau_pkg.sv
package cau_pkg;
  localparam int REG_W  = 32;
  localparam int PTR_W  = 4;
  localparam int CFG_W  = 20;
  localparam int NCACHE = 3;

  typedef enum logic [1:0] {
    SEL_CMD = 2'd0,
    SEL_EXP = 2'd1,
    SEL_RDD = 2'd2,
    SEL_RSV = 2'd3
  } csel_e;

  typedef struct packed {
    logic [PTR_W-1:0] slice;
    logic [PTR_W-1:0] word;
  } ptr_t;

  // packed order places fields at their register bit positions
  typedef struct packed {
    ptr_t  rd;
    logic  is_read;
    logic  auto_inc;
    csel_e target;
    ptr_t  wr;
  } cfg_t;

  // slice-major step: slices of a word first, then the next word
  function automatic ptr_t ptr_step(ptr_t cur, logic [PTR_W-1:0] last_slice,
                                    logic [PTR_W-1:0] last_word);
    ptr_t nxt;
    nxt = cur;
    if (cur.slice >= last_slice) begin
      nxt.slice = '0;
      nxt.word  = (cur.word >= last_word) ? '0 : cur.word + 1'b1;
    end else begin
      nxt.slice = cur.slice + 1'b1;
    end
    return nxt;
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_reg(cfg_t c);
    return {{(REG_W-CFG_W){1'b0}}, c};
  endfunction
endpackage

// File: rtl/cau_ctrl_reg.sv
module cau_ctrl_reg
  import cau_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [REG_W-1:0] sw_wdata,
  input  logic             step_wr,
  input  logic             step_rd,
  input  ptr_t             ptr_next,
  output cfg_t             cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (sw_we) begin
      cfg <= cfg_t'(sw_wdata[CFG_W-1:0]);
    end else begin
      if (step_wr) cfg.wr <= ptr_next;
      if (step_rd) cfg.rd <= ptr_next;
    end
  end
endmodule

// File: rtl/cau_ptr_step.sv
module cau_ptr_step
  import cau_pkg::*;
#(
  parameter int CMD_WORDS  = 16,
  parameter int CMD_SLICES = 4,
  parameter int EXP_WORDS  = 16,
  parameter int EXP_SLICES = 2,
  parameter int RDD_WORDS  = 16,
  parameter int RDD_SLICES = 2
) (
  input  ptr_t  cur,
  input  csel_e target,
  output ptr_t  nxt
);
  localparam int WORDS  [NCACHE] = '{CMD_WORDS, EXP_WORDS, RDD_WORDS};
  localparam int SLICES [NCACHE] = '{CMD_SLICES, EXP_SLICES, RDD_SLICES};

  ptr_t cand [NCACHE];

  for (genvar g = 0; g < NCACHE; g++) begin : g_cand
    assign cand[g] = ptr_step(cur, PTR_W'(SLICES[g] - 1), PTR_W'(WORDS[g] - 1));
  end

  always_comb begin
    case (target)
      SEL_CMD: nxt = cand[0];
      SEL_EXP: nxt = cand[1];
      SEL_RDD: nxt = cand[2];
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/cau_rdata_win.sv
module cau_rdata_win
  import cau_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_fire,
  input  csel_e                     target,
  input  logic [NCACHE-1:0][DW-1:0] src,
  output logic [DW-1:0]             dat_rdata
);
  logic [DW-1:0] picked;

  always_comb begin
    case (target)
      SEL_CMD: picked = src[0];
      SEL_EXP: picked = src[1];
      SEL_RDD: picked = src[2];
      default: picked = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       dat_rdata <= '0;
    else if (rd_fire) dat_rdata <= picked;
  end
endmodule

// File: rtl/cache_addr_unit.sv
module cache_addr_unit
  import cau_pkg::*;
#(
  parameter int DW         = 32,
  parameter int CMD_WORDS  = 16,
  parameter int CMD_SLICES = 4,
  parameter int EXP_WORDS  = 16,
  parameter int EXP_SLICES = 2,
  parameter int RDD_WORDS  = 16,
  parameter int RDD_SLICES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          dat_acc,
  input  logic [DW-1:0] dat_wdata,
  output logic [DW-1:0] dat_rdata,
  output logic [2:0]    cache_cs,
  output logic          cache_we,
  output logic [3:0]    cache_word,
  output logic [3:0]    cache_slice,
  output logic [DW-1:0] cache_wdata,
  input  logic [DW-1:0] cmd_rdata,
  input  logic [DW-1:0] exp_rdata,
  input  logic [DW-1:0] rdd_rdata
);
  cfg_t cfg;
  ptr_t act_ptr;
  ptr_t ptr_next;

  // named internal events
  logic acc_valid;
  logic step_en;
  logic step_wr;
  logic step_rd;
  logic rd_fire;

  assign act_ptr   = cfg.is_read ? cfg.rd : cfg.wr;
  assign acc_valid = dat_acc && (cfg.target != SEL_RSV);
  assign step_en   = acc_valid && cfg.auto_inc && !reg_wr_en;
  assign step_wr   = step_en && !cfg.is_read;
  assign step_rd   = step_en && cfg.is_read;
  assign rd_fire   = dat_acc && cfg.is_read;

  cau_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (reg_wr_en),
    .sw_wdata (reg_wdata),
    .step_wr  (step_wr),
    .step_rd  (step_rd),
    .ptr_next (ptr_next),
    .cfg      (cfg)
  );

  cau_ptr_step #(
    .CMD_WORDS (CMD_WORDS), .CMD_SLICES (CMD_SLICES),
    .EXP_WORDS (EXP_WORDS), .EXP_SLICES (EXP_SLICES),
    .RDD_WORDS (RDD_WORDS), .RDD_SLICES (RDD_SLICES)
  ) u_step (
    .cur    (act_ptr),
    .target (cfg.target),
    .nxt    (ptr_next)
  );

  cau_rdata_win #(.DW(DW)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_fire),
    .target    (cfg.target),
    .src       ({rdd_rdata, exp_rdata, cmd_rdata}),
    .dat_rdata (dat_rdata)
  );

  assign reg_rdata   = cfg_to_reg(cfg);
  assign cache_cs    = acc_valid ? (3'b001 << cfg.target) : 3'b000;
  assign cache_we    = acc_valid && !cfg.is_read;
  assign cache_word  = act_ptr.word;
  assign cache_slice = act_ptr.slice;
  assign cache_wdata = dat_wdata;
endmodule

// File: rtl/cau_checker.sv
module cau_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr_en,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          dat_acc,
  input logic [DW-1:0] dat_rdata,
  input logic [2:0]    cache_cs,
  input logic          cache_we,
  input logic          step_en
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:20] == 12'h000);

  p_sw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_rdata == ($past(reg_wdata) & 32'h000F_FFFF));

  p_no_step_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && !step_en) |=> $stable(reg_rdata));

  p_write_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cache_we |-> (dat_acc && !reg_rdata[11]));

  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cache_cs));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_acc |-> (cache_cs == 3'b000 && !cache_we));

  p_rsv_no_cache_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_acc && reg_rdata[9:8] == 2'b11) |-> (cache_cs == 3'b000 && !cache_we));

  p_rsv_zero_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_acc && reg_rdata[11] && reg_rdata[9:8] == 2'b11) |=> dat_rdata == '0);

  p_rd_keeps_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_acc && !reg_wr_en && reg_rdata[11]) |=> $stable(reg_rdata[7:0]));

  p_wr_keeps_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_acc && !reg_wr_en && !reg_rdata[11]) |=> $stable(reg_rdata[19:12]));
endmodule

bind cache_addr_unit cau_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .dat_acc   (dat_acc),
  .dat_rdata (dat_rdata),
  .cache_cs  (cache_cs),
  .cache_we  (cache_we),
  .step_en   (step_en)
);

// File: tb/cache_addr_unit_tb.sv
`timescale 1ns/1ps
module cache_addr_unit_tb;
  localparam int DW = 32;
  localparam int NW [3] = '{4, 2, 3};
  localparam int NS [3] = '{3, 2, 4};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          dat_acc = 1'b0;
  logic [DW-1:0] dat_wdata = '0;
  logic [DW-1:0] dat_rdata;
  logic [2:0]    cache_cs;
  logic          cache_we;
  logic [3:0]    cache_word, cache_slice;
  logic [DW-1:0] cache_wdata;
  logic [DW-1:0] cmd_rdata, exp_rdata, rdd_rdata;

  always #4 clk = ~clk;

  function automatic logic [31:0] pat(input int c, input logic [3:0] w, input logic [3:0] s);
    return {6'h2A, 2'(c), 4'h0, w, 4'h0, s, 8'h5A};
  endfunction

  assign cmd_rdata = pat(0, cache_word, cache_slice);
  assign exp_rdata = pat(1, cache_word, cache_slice);
  assign rdd_rdata = pat(2, cache_word, cache_slice);

  cache_addr_unit #(
    .DW(DW), .CMD_WORDS(4), .CMD_SLICES(3), .EXP_WORDS(2), .EXP_SLICES(2),
    .RDD_WORDS(3), .RDD_SLICES(4)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dat_acc(dat_acc), .dat_wdata(dat_wdata),
    .dat_rdata(dat_rdata), .cache_cs(cache_cs), .cache_we(cache_we),
    .cache_word(cache_word), .cache_slice(cache_slice), .cache_wdata(cache_wdata),
    .cmd_rdata(cmd_rdata), .exp_rdata(exp_rdata), .rdd_rdata(rdd_rdata)
  );

  typedef struct {
    bit          is_rd;
    logic [2:0]  cs;
    logic [3:0]  w;
    logic [3:0]  s;
    logic [31:0] d;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit rd_pend = 0;
  logic [19:0] mreg = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // linear-index restatement of the stepping order
  function automatic logic [7:0] bstep(input logic [7:0] p, input int c);
    int idx;
    idx = int'(p[3:0]) * NS[c] + int'(p[7:4]);
    idx = (idx + 1) % (NS[c] * NW[c]);
    return {4'(idx % NS[c]), 4'(idx / NS[c])};
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] rs, rw, input bit at, inc,
                                     input logic [1:0] cs, input logic [3:0] ws, ww);
    return {12'h000, rs, rw, at, inc, cs, ws, ww};
  endfunction

  task automatic wreg(input logic [31:0] v);
    reg_wr_en = 1'b1; reg_wdata = v;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
    mreg = v[19:0];
  endtask

  // driver: pushes the expected item, then strobes the data window
  task automatic access(input logic [31:0] wd, input string req,
                        input bit with_reg = 0, input logic [31:0] regv = '0);
    item_t it;
    int c;
    bit rd;
    logic [7:0] p;
    c  = int'(mreg[9:8]);
    rd = mreg[11];
    p  = rd ? mreg[19:12] : mreg[7:0];
    it.is_rd = rd; it.req = req;
    it.w = p[3:0]; it.s = p[7:4];
    if (c != 3) begin
      it.cs = 3'b001 << c;
      it.d  = rd ? pat(c, p[3:0], p[7:4]) : wd;
      q.push_back(it);
    end else if (rd) begin
      it.cs = 3'b000; it.d = '0;
      q.push_back(it);
    end
    dat_acc = 1'b1; dat_wdata = wd;
    reg_wr_en = with_reg; reg_wdata = regv;
    @(posedge clk); #1;
    dat_acc = 1'b0; reg_wr_en = 1'b0;
    if (with_reg) mreg = regv[19:0];
    else if (c != 3 && mreg[10]) begin
      if (rd) mreg[19:12] = bstep(mreg[19:12], c);
      else    mreg[7:0]   = bstep(mreg[7:0], c);
    end
  endtask

  // monitor: compares design outputs against queued items
  always @(negedge clk) begin
    item_t it;
    if (rst_n) begin
      if (rd_pend) begin
        rd_pend = 0;
        if (q.size() == 0) chk(0, "R10 read queue empty", 64'(dat_rdata), 0);
        else begin
          it = q.pop_front();
          chk(dat_rdata == it.d, {it.req, " R10 read data"}, 64'(dat_rdata), 64'(it.d));
        end
      end
      if (dat_acc) begin
        if (reg_rdata[11]) begin
          rd_pend = 1;
          if (q.size() == 0) chk(0, "R3 read item missing", 0, 0);
          else begin
            it = q[0];
            chk(cache_cs == it.cs && !cache_we &&
                (it.cs == 0 || (cache_word == it.w && cache_slice == it.s)),
                {it.req, " R3 R4 read address"},
                64'({cache_cs, cache_we, cache_word, cache_slice}),
                64'({it.cs, 1'b0, it.w, it.s}));
          end
        end else if (reg_rdata[9:8] == 2'b11) begin
          chk(cache_cs == 3'b000 && !cache_we, "R5 reserved write quiet",
              64'({cache_cs, cache_we}), 0);
        end else if (q.size() == 0) begin
          chk(0, "R3 write item missing", 0, 0);
        end else begin
          it = q.pop_front();
          chk(cache_cs == it.cs && cache_we && cache_word == it.w &&
              cache_slice == it.s && cache_wdata == it.d,
              {it.req, " R3 R4 write"},
              64'({cache_cs, cache_we, cache_word, cache_slice, cache_wdata}),
              64'({it.cs, 1'b1, it.w, it.s, it.d}));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(reg_rdata == 32'h0, "R1 reset register", 64'(reg_rdata), 0);
    chk(dat_rdata == '0 && cache_cs == 3'b000, "R1 reset outputs",
        64'({dat_rdata, cache_cs}), 0);

    // R1 reserved bits read zero
    wreg(32'hFFFF_FFFF);
    chk(reg_rdata == 32'h000F_FFFF, "R1 reserved bits", 64'(reg_rdata), 64'h000F_FFFF);

    // R2 field readback
    wreg(32'hABC0_0000 | mk(4'h5, 4'h6, 1, 0, 2'b10, 4'h7, 4'h9));
    chk(reg_rdata[19:16] == 4'h5 && reg_rdata[15:12] == 4'h6 && reg_rdata[11] &&
        !reg_rdata[10] && reg_rdata[9:8] == 2'b10 && reg_rdata[7:4] == 4'h7 &&
        reg_rdata[3:0] == 4'h9, "R2 field layout", 64'(reg_rdata), 64'h5_6A79);

    // R3 R6 writes with stepping off
    wreg(mk(4'h1, 4'h1, 0, 0, 2'b00, 4'h1, 4'h2));
    access(32'hDEAD_0001, "R6 hold");
    access(32'hDEAD_0002, "R6 hold");
    chk(reg_rdata[19:0] == mreg, "R6 pointers held", 64'(reg_rdata), 64'(mreg));

    // R7 R8 write pointer stepping with word wrap in the command cache
    wreg(mk(4'h2, 4'h1, 0, 1, 2'b00, 4'h1, 4'h3));
    for (int i = 0; i < 4; i++) access(32'hC0DE_0000 + i, "R7 cmd write step");
    chk(reg_rdata[7:0] == 8'h20, "R7 write ptr wrap", 64'(reg_rdata[7:0]), 64'h20);
    chk(reg_rdata[19:12] == 8'h21, "R8 read ptr untouched", 64'(reg_rdata[19:12]), 64'h21);

    // R7 R8 read pointer stepping in the expected-data cache
    wreg(mk(4'h1, 4'h1, 1, 1, 2'b01, 4'h1, 4'h0));
    for (int i = 0; i < 3; i++) access('0, "R7 exp read step");
    chk(reg_rdata[19:0] == mreg, "R7 exp pointer", 64'(reg_rdata), 64'(mreg));
    chk(reg_rdata[7:0] == 8'h10, "R8 write ptr untouched", 64'(reg_rdata[7:0]), 64'h10);

    // R7 read-data cache: four slices, three words
    wreg(mk(4'h2, 4'h2, 1, 1, 2'b10, 4'h0, 4'h0));
    for (int i = 0; i < 5; i++) access('0, "R7 rdd read step");
    chk(reg_rdata[19:12] == 8'h30, "R7 rdd wrap", 64'(reg_rdata[19:12]), 64'h30);

    // R10 pointer step visible at the same edge as the data
    access('0, "R10 single read");
    chk(reg_rdata[19:12] == 8'h01, "R10 step timing", 64'(reg_rdata[19:12]), 64'h01);

    // R5 reserved target
    wreg(mk(4'h1, 4'h1, 1, 1, 2'b11, 4'h1, 4'h1));
    access('0, "R5 reserved read");
    chk(reg_rdata[19:0] == mreg, "R5 pointers frozen", 64'(reg_rdata), 64'(mreg));
    wreg(mk(4'h1, 4'h1, 0, 1, 2'b11, 4'h1, 4'h1));
    access(32'h5555_5555, "R5 reserved write");
    chk(reg_rdata[19:0] == mreg, "R5 write ptr frozen", 64'(reg_rdata), 64'(mreg));

    // R9 software write beats the step
    wreg(mk(4'h0, 4'h0, 0, 1, 2'b00, 4'h0, 4'h1));
    access(32'h9999_0009, "R9 collision", 1, mk(4'h2, 4'h3, 1, 0, 2'b01, 4'h1, 4'h1));
    chk(reg_rdata == mk(4'h2, 4'h3, 1, 0, 2'b01, 4'h1, 4'h1), "R9 register wins",
        64'(reg_rdata), 64'(mk(4'h2, 4'h3, 1, 0, 2'b01, 4'h1, 4'h1)));

    repeat (3) @(posedge clk);
    #1;
    chk(q.size() == 0, "R10 all results seen", 64'(q.size()), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule